// File: doc/BRIEF.md
# Clock-Gated Latch Register File

This block is the integer register file of a small RISC-V core. It holds the full set of 32 architectural registers of 32 bits each, which is 1 kbit in total. It has one write port and two read ports, and reads are combinational. Storage is built from level-sensitive latches rather than flip-flops. Each stored word has its own clock-gate cell, and the output of that cell is the shared latch enable for all 32 bits of the word.

A write request (enable, address, data) is registered on the rising clock edge. The addressed word's gate then opens during the low phase that follows, while the registered data is steady, and the latches follow it. When the clock rises again the gate closes, and the word holds the new value.

Register zero has no storage at all. Reads of it return zero, and writes to it are dropped when they are captured. A read of the register being written in the same cycle returns the old contents. The new contents are visible on both ports from the next cycle on.

Top module: `rf_latch_regfile`

## Requirements
- R1: A read of address 0 on either port returns 0, both during reset and after it.
- R2: A write to address 0 is discarded. Address 0 continues to read as 0 on both ports.
- R3: A write presented with `wr_en`=1 in cycle N to an address between 1 and 31 is returned by both read ports for that address from cycle N+1 onward.
- R4: A read in cycle N of the address being written in cycle N returns the value that was stored before that write.
- R5: A write changes only the addressed register. Every other register keeps its value.
- R6: A cycle with `wr_en`=0 changes no register, whatever is on `wr_addr` and `wr_data`.
- R7: The two read ports are independent. In the same cycle, each returns the contents of its own address.
- R8: Writes to the same register in back-to-back cycles each become visible in the following cycle, and the last write is the one that persists.
- R9: Writes to distinct registers in consecutive cycles each land in their own register. At most one word's gate is open at a time, and no gate is open while the clock is high.
- R10: While `rst_n` is low, a requested write is not performed. The registered write request is cleared and the stored registers keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; a write is captured on the rising edge and stored during the following low phase |
| rst_n | input | 1 | Asynchronous active-low reset of the write request register |
| wr_en | input | 1 | Write request |
| wr_addr | input | 5 | Register to write |
| wr_data | input | 32 | Value to write |
| rd_addr_a | input | 5 | Read port A address |
| rd_data_a | output | 32 | Read port A data (combinational) |
| rd_addr_b | input | 5 | Read port B address |
| rd_data_b | output | 32 | Read port B data (combinational) |

## Verification
Suppose a gate opens for the wrong word, or opens on the wrong phase. The damage then stays hidden in storage until some later read of the corrupted register. A reference model that is compared on every cycle, on both ports, for every initialised register, catches the corruption on the first read after it happens. A wrong capture or a wrong forwarding order shows up at once, in the cycle of the write or the cycle after. That is why directed same-cycle and back-to-back cases are run in addition to a long random stream with frequent address collisions.

// File: rtl/rf_latch_pkg.sv
package rf_latch_pkg;
    localparam int RF_XLEN_DEF = 32;
    localparam int RF_REGS_DEF = 32;

    // true when an address names the hard-wired zero register
    function automatic logic rf_is_zero(input logic [7:0] addr);
        return addr == 8'd0;
    endfunction
endpackage

// File: rtl/rf_icg.sv
// Behavioural integrated clock gate: enable latched while clock is low.
module rf_icg (
    input  logic clk_i,
    input  logic en_i,
    output logic gclk_o
);
    logic en_l;

    always_latch begin
        if (!clk_i) begin
            en_l <= en_i;
        end
    end

    assign gclk_o = clk_i & en_l;
endmodule

// File: rtl/rf_word.sv
// One stored register: a clock gate plus a word of transparent latches.
module rf_word #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel_i,
    input  logic [XLEN-1:0] wdata_i,
    output logic            gate_o,
    output logic [XLEN-1:0] q_o
);
    logic clk_n;

    // the gate opens in the low phase of clk
    assign clk_n = ~clk;

    rf_icg i_icg (
        .clk_i  (clk_n),
        .en_i   (sel_i),
        .gclk_o (gate_o)
    );

    always_latch begin
        if (gate_o) begin
            q_o <= wdata_i;
        end
    end

    // an unselected word must not move across a full cycle
    assert_hold_unselected_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        !sel_i |-> $stable(q_o)
    );
endmodule

// File: rtl/rf_rd_port.sv
// Combinational read selection over the word array.
module rf_rd_port #(
    parameter int NUM_REGS = 32,
    parameter int XLEN     = 32,
    localparam int AW      = $clog2(NUM_REGS)
) (
    input  logic [XLEN-1:0] words_i [NUM_REGS],
    input  logic [AW-1:0]   addr_i,
    output logic [XLEN-1:0] data_o
);
    always_comb begin
        data_o = words_i[addr_i];
        if (rf_latch_pkg::rf_is_zero(8'(addr_i))) begin
            data_o = '0;
        end
    end
endmodule

// File: rtl/rf_latch_regfile.sv
module rf_latch_regfile #(
    parameter int NUM_REGS = rf_latch_pkg::RF_REGS_DEF,
    parameter int XLEN     = rf_latch_pkg::RF_XLEN_DEF,
    localparam int AW      = $clog2(NUM_REGS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [XLEN-1:0] wr_data,
    input  logic [AW-1:0]   rd_addr_a,
    output logic [XLEN-1:0] rd_data_a,
    input  logic [AW-1:0]   rd_addr_b,
    output logic [XLEN-1:0] rd_data_b
);
    typedef struct packed {
        logic            en;
        logic [AW-1:0]   addr;
        logic [XLEN-1:0] data;
    } wr_req_t;

    wr_req_t wr_d, wr_q;

    logic [XLEN-1:0]     words [NUM_REGS];
    logic [NUM_REGS-1:0] gates;

    // next-state: capture the request, dropping writes to the zero register
    always_comb begin
        wr_d      = wr_q;
        wr_d.en   = wr_en && !rf_latch_pkg::rf_is_zero(8'(wr_addr));
        wr_d.addr = wr_addr;
        wr_d.data = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q <= '0;
        end else begin
            wr_q <= wr_d;
        end
    end

    // register zero: no storage, constant output
    assign words[0] = '0;
    assign gates[0] = 1'b0;

    for (genvar g = 1; g < NUM_REGS; g++) begin : g_word
        logic sel;
        assign sel = wr_q.en && (wr_q.addr == AW'(g));

        rf_word #(.XLEN(XLEN)) i_word (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel_i   (sel),
            .wdata_i (wr_q.data),
            .gate_o  (gates[g]),
            .q_o     (words[g])
        );
    end

    rf_rd_port #(.NUM_REGS(NUM_REGS), .XLEN(XLEN)) i_rd_a (
        .words_i (words),
        .addr_i  (rd_addr_a),
        .data_o  (rd_data_a)
    );

    rf_rd_port #(.NUM_REGS(NUM_REGS), .XLEN(XLEN)) i_rd_b (
        .words_i (words),
        .addr_i  (rd_addr_b),
        .data_o  (rd_data_b)
    );

    assert_zero_port_a_R1: assert property (
        @(posedge clk) disable iff (!rst_n)
        (rd_addr_a == '0) |-> (rd_data_a == '0)
    );

    assert_zero_port_b_R1: assert property (
        @(posedge clk) disable iff (!rst_n)
        (rd_addr_b == '0) |-> (rd_data_b == '0)
    );

    assert_gates_closed_high_R9: assert property (
        @(negedge clk) disable iff (!rst_n)
        gates == '0
    );

    assert_one_gate_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        $onehot0(gates)
    );

    assert_gate_needs_request_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        (|gates) |-> (wr_q.en && wr_q.addr != '0)
    );
endmodule

// File: tb/test_rf_latch_regfile.sv
`timescale 1ns/1ps
module test_rf_latch_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_addr_a = '0;
    logic [4:0]  rd_addr_b = '0;
    logic [31:0] rd_data_a, rd_data_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] model [32];
    bit          valid [32];

    always #2.5 clk = ~clk;

    rf_latch_regfile i_rf_latch_regfile (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr_a (rd_addr_a),
        .rd_data_a (rd_data_a),
        .rd_addr_b (rd_addr_b),
        .rd_data_b (rd_data_b)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // one cycle: drive after the rising edge, compare in the low phase,
    // then apply this cycle's write to the model (it lands at the next edge)
    task automatic step(input bit we, input logic [4:0] wa, input logic [31:0] wd,
                        input logic [4:0] ra, input logic [4:0] rb, input string tag);
        @(posedge clk);
        #1;
        wr_en = we; wr_addr = wa; wr_data = wd;
        rd_addr_a = ra; rd_addr_b = rb;
        #3;
        if (valid[ra]) chk({tag, " port A"}, rd_data_a, model[ra]);
        if (valid[rb]) chk({tag, " port B"}, rd_data_b, model[rb]);
        if (rst_n && we && wa != 5'd0) begin
            model[wa] = wd;
            valid[wa] = 1'b1;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) begin
            model[i] = '0;
            valid[i] = (i == 0);
        end
        // R1: zero register reads 0 during reset
        step(1'b0, 5'd0, 32'h0, 5'd0, 5'd0, "R1 reset");
        step(1'b0, 5'd0, 32'h0, 5'd0, 5'd0, "R1 reset");
        @(negedge clk); #1; rst_n = 1'b1;

        // fill every register; R3 checks the previous one next cycle
        for (int i = 1; i < 32; i++) begin
            step(1'b1, 5'(i), 32'hA500_0000 | 32'(i * 32'h0101), 5'(i - 1), 5'd0, "R3 fill");
        end
        step(1'b0, 5'd0, 32'h0, 5'd31, 5'd30, "R3");

        // R4 then R3: same-cycle read sees old value
        step(1'b1, 5'd5, 32'h1234_5678, 5'd5, 5'd5, "R4");
        step(1'b0, 5'd0, 32'h0, 5'd5, 5'd5, "R3");

        // R2: write to zero register dropped
        step(1'b1, 5'd0, 32'hDEAD_BEEF, 5'd0, 5'd0, "R2");
        step(1'b0, 5'd0, 32'h0, 5'd0, 5'd0, "R2");

        // R8: back-to-back writes to one register
        step(1'b1, 5'd9, 32'hAAAA_0001, 5'd9, 5'd9, "R8");
        step(1'b1, 5'd9, 32'hBBBB_0002, 5'd9, 5'd9, "R8");
        step(1'b0, 5'd0, 32'h0, 5'd9, 5'd9, "R8");

        // R9: consecutive distinct registers
        step(1'b1, 5'd10, 32'h0000_0A0A, 5'd10, 5'd11, "R9");
        step(1'b1, 5'd11, 32'h0000_0B0B, 5'd10, 5'd11, "R9");
        step(1'b1, 5'd12, 32'h0000_0C0C, 5'd11, 5'd12, "R9");
        step(1'b0, 5'd0, 32'h0, 5'd12, 5'd10, "R9");

        // R6: disabled write leaves register untouched
        step(1'b0, 5'd3, 32'hFFFF_FFFF, 5'd3, 5'd3, "R6");
        step(1'b0, 5'd3, 32'hFFFF_FFFF, 5'd3, 5'd3, "R6");

        // R7: independent ports
        step(1'b0, 5'd0, 32'h0, 5'd4, 5'd31, "R7");
        step(1'b0, 5'd0, 32'h0, 5'd31, 5'd4, "R7");

        // R10: write requested under reset is not performed
        @(negedge clk); #1; rst_n = 1'b0;
        step(1'b1, 5'd7, 32'h7777_7777, 5'd0, 5'd0, "R10 reset");
        step(1'b1, 5'd7, 32'h7777_7777, 5'd0, 5'd0, "R10 reset");
        @(negedge clk); #1; wr_en = 1'b0; rst_n = 1'b1;
        step(1'b0, 5'd0, 32'h0, 5'd7, 5'd7, "R10");
        step(1'b0, 5'd0, 32'h0, 5'd7, 5'd7, "R10");

        // R5: random traffic with frequent collisions
        for (int n = 0; n < 3000; n++) begin
            logic [4:0] wa;
            wa = (n % 3 == 0) ? 5'($urandom % 4) : 5'($urandom);
            step(($urandom % 4) != 0, wa, $urandom,
                 (n % 2 == 0) ? wa : 5'($urandom), 5'($urandom), "R5");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule